// File: doc/BRIEF.md
# Receive Descriptor Chain Walker

This block moves incoming frame data into host receive buffers that software describes with a linked chain of 16-byte descriptors. All descriptors sit in one contiguous area. Its base address comes from a global register input, and each descriptor is found by its 16-bit index within that area. Each channel keeps its own index of the next descriptor to use. Software sets this index with a head-load strobe, and the block advances it as buffers are completed.

For every frame the block reads the control word of the channel's current descriptor and accepts it only if its sync field says ready. It then reads the buffer pointer and writes 8-byte payload words into the buffer. When the buffer is full or the frame ends, it checks whether the following descriptor is ready and writes back the byte count, the end-of-frame flag and a done state. It then moves to the next descriptor. If descriptors run out while data remains, the rest of the frame is consumed and discarded, and an error event is raised. A completion event carrying the channel number marks each descriptor written back with end-of-frame.

The memory port is 64 bits wide and addressed in 8-byte words. A request is always taken, and read data returns on the cycle after the request.

Top module: `rxw_walker`

## Requirements
- R1: The descriptor at index i starts at byte address `area_base` (low 4 bits ignored) + 16*i. Its word at offset 0 holds the buffer byte address in bits [31:0]. Its word at offset 8 is the control word, laid out as: next index [15:0], length or byte count [31:16], sync [33:32], end-of-frame [34], remaining bits zero.
- R2: The sync encodings are 0 = done with valid link, 1 = done with invalid link, 2 = not ready and 3 = ready. A frame that starts on a descriptor that is not ready writes nothing and is discarded whole.
- R3: Payload words go to consecutive 8-byte words from the buffer address, and no more than length/8 words go into any buffer.
- R4: When a frame fills a buffer and the next descriptor is ready, the frame continues at the buffer of the next descriptor, reached through the next index.
- R5: Write-back keeps the next index and replaces the length with the number of bytes written. The end-of-frame bit is set only in the descriptor whose buffer got the frame's last word.
- R6: The written-back sync is 0 if the next descriptor was ready when the buffer completed, and 1 otherwise.
- R7: A frame that ends part way through a buffer leaves the rest of that buffer unused, and the channel's next frame starts at the next descriptor.
- R8: If the chain runs out while frame data remains, all remaining words are accepted and none is written to memory. A one-cycle `drop_valid` with the channel follows the frame's last word.
- R9: Any number of discarded frames in a row leaves the block idle and able to serve the next frame normally.
- R10: `done_valid` pulses for one cycle with the channel for each descriptor written back with end-of-frame, and never in the same cycle as `drop_valid`.
- R11: `hd_load` sets the selected channel's current index. Channels advance independently.
- R12: After reset, no memory request, no frame-ready and no event are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| area_base | input | 32 | Byte address of the descriptor area |
| hd_load | input | 1 | Load strobe for a channel's current index |
| hd_chan | input | CHW | Channel selected by the load |
| hd_index | input | 16 | Index loaded |
| frm_valid | input | 1 | Frame word present |
| frm_ready | output | 1 | Frame word accepted this cycle |
| frm_chan | input | CHW | Channel of the frame, held for the whole frame |
| frm_data | input | 64 | Frame word |
| frm_last | input | 1 | Word is the frame's last |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 29 | Memory address in 8-byte words |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, one cycle after a read request |
| done_valid | output | 1 | End-of-frame descriptor written back |
| done_chan | output | CHW | Channel of that descriptor |
| drop_valid | output | 1 | Frame data discarded |
| drop_chan | output | CHW | Channel of the discarded frame |

## Verification
The buffer-bound assertion assumes that every descriptor marked ready carries a nonzero length that is a multiple of 8. It also assumes that `frm_chan` stays constant within a frame and that memory answers reads on the following cycle. The bench builds every chain with lengths of 8 to 24 bytes and holds the channel for each frame. Its memory model answers every request one cycle later. Head loads are issued only while the block is idle.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int DW   = 64;
  localparam int BAW  = 32;
  localparam int MAW  = BAW - 3;
  localparam int IDXW = 16;
  localparam int LENW = 16;
  localparam int BTW  = LENW - 3;

  localparam logic [1:0] SY_DONE_OK  = 2'd0;
  localparam logic [1:0] SY_DONE_BRK = 2'd1;
  localparam logic [1:0] SY_HOLD     = 2'd2;
  localparam logic [1:0] SY_READY    = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RD1, S_RD1W, S_RD0W, S_FILL, S_PEEK, S_PEEKW, S_WB, S_DROP
  } st_t;

  typedef enum logic [1:0] { A_CTL, A_PTR, A_BUF, A_PEEK } asel_t;

  // word address of one half of a descriptor (hi=1: control word)
  function automatic logic [MAW-1:0] dsc_word(input logic [BAW-1:0] base,
                                              input logic [IDXW-1:0] idx,
                                              input logic hi);
    logic [BAW-5:0] blk;
    blk = base[BAW-1:4] + {{(BAW-4-IDXW){1'b0}}, idx};
    return {blk, hi};
  endfunction

  function automatic logic [MAW-1:0] buf_word(input logic [BAW-1:0] addr,
                                              input logic [BTW-1:0] beat);
    return addr[BAW-1:3] + {{(MAW-BTW){1'b0}}, beat};
  endfunction

  function automatic logic [DW-1:0] pack_ctl(input logic [IDXW-1:0] nxt,
                                             input logic [LENW-1:0] cnt,
                                             input logic [1:0] sy,
                                             input logic eof);
    return {{(DW-IDXW-LENW-3){1'b0}}, eof, sy, cnt, nxt};
  endfunction
endpackage

// File: rtl/rxw_head_table.sv
module rxw_head_table #(
  parameter int NCHAN = 4,
  localparam int CHW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [CHW-1:0]            ld_ch,
  input  logic [rxw_pkg::IDXW-1:0]  ld_idx,
  input  logic                      adv_en,
  input  logic [CHW-1:0]            adv_ch,
  input  logic [rxw_pkg::IDXW-1:0]  adv_idx,
  input  logic [CHW-1:0]            rd_ch,
  output logic [rxw_pkg::IDXW-1:0]  rd_idx
);
  logic [rxw_pkg::IDXW-1:0] tbl [NCHAN];

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCHAN; c++) begin
      if (!rst_n) tbl[c] <= '0;
      else if (ld_en && ld_ch == CHW'(c)) tbl[c] <= ld_idx;
      else if (adv_en && adv_ch == CHW'(c)) tbl[c] <= adv_idx;
    end
  end

  assign rd_idx = tbl[rd_ch];

  for (genvar g = 0; g < NCHAN; g++) begin : g_chk
    // R11
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_ch == CHW'(g)) |=> tbl[g] == $past(ld_idx));
  end
endmodule

// File: rtl/rxw_addr_gen.sv
module rxw_addr_gen
  import rxw_pkg::*;
(
  input  asel_t             sel,
  input  logic [BAW-1:0]    base,
  input  logic [IDXW-1:0]   cur_idx,
  input  logic [IDXW-1:0]   nxt_idx,
  input  logic [BAW-1:0]    buf_addr,
  input  logic [BTW-1:0]    beat,
  output logic [MAW-1:0]    addr
);
  always_comb begin
    unique case (sel)
      A_CTL:   addr = dsc_word(base, cur_idx, 1'b1);
      A_PTR:   addr = dsc_word(base, cur_idx, 1'b0);
      A_PEEK:  addr = dsc_word(base, nxt_idx, 1'b1);
      default: addr = buf_word(buf_addr, beat);
    endcase
  end
endmodule

// File: rtl/rxw_walker.sv
module rxw_walker
  import rxw_pkg::*;
#(
  parameter int NCHAN = 4,
  localparam int CHW = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      area_base,
  input  logic             hd_load,
  input  logic [CHW-1:0]   hd_chan,
  input  logic [15:0]      hd_index,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [CHW-1:0]   frm_chan,
  input  logic [63:0]      frm_data,
  input  logic             frm_last,
  output logic             mem_req,
  output logic             mem_we,
  output logic [28:0]      mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic [63:0]      mem_rdata,
  output logic             done_valid,
  output logic [CHW-1:0]   done_chan,
  output logic             drop_valid,
  output logic [CHW-1:0]   drop_chan
);
  st_t               state;
  logic [CHW-1:0]    ch;
  logic [IDXW-1:0]   cur_idx, nxt_idx, tbl_idx;
  logic [LENW-1:0]   buf_len;
  logic [BAW-1:0]    buf_addr;
  logic [BTW-1:0]    beats;
  logic              eof, nxt_rdy;
  asel_t             asel;

  // decoded control word fields
  logic [1:0]        rd_sync;
  logic [IDXW-1:0]   rd_next;
  logic [LENW-1:0]   rd_len;
  assign rd_sync = mem_rdata[33:32];
  assign rd_next = mem_rdata[15:0];
  assign rd_len  = mem_rdata[31:16];

  // named internal events
  logic              take_word, buf_full, wb_fire, drop_end;
  logic [BTW-1:0]    beats_n;
  assign take_word = (state == S_FILL) && frm_valid;
  assign beats_n   = beats + BTW'(1);
  assign buf_full  = {beats_n, 3'b000} >= buf_len;
  assign wb_fire   = (state == S_WB);
  assign drop_end  = (state == S_DROP) && frm_valid && frm_last;

  rxw_head_table #(.NCHAN(NCHAN)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .ld_en(hd_load), .ld_ch(hd_chan), .ld_idx(hd_index),
    .adv_en(wb_fire), .adv_ch(ch), .adv_idx(nxt_idx),
    .rd_ch((state == S_IDLE) ? frm_chan : ch), .rd_idx(tbl_idx)
  );

  rxw_addr_gen u_ag (
    .sel(asel), .base(area_base), .cur_idx(cur_idx), .nxt_idx(nxt_idx),
    .buf_addr(buf_addr), .beat(beats), .addr(mem_addr)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    asel      = A_CTL;
    frm_ready = 1'b0;
    mem_wdata = frm_data;
    unique case (state)
      S_RD1:  mem_req = 1'b1;
      S_RD1W: begin
        mem_req = (rd_sync == SY_READY);
        asel    = A_PTR;
      end
      S_FILL: begin
        frm_ready = 1'b1;
        asel      = A_BUF;
        mem_req   = frm_valid;
        mem_we    = frm_valid;
      end
      S_PEEK: begin
        mem_req = 1'b1;
        asel    = A_PEEK;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pack_ctl(nxt_idx, {beats, 3'b000},
                             nxt_rdy ? SY_DONE_OK : SY_DONE_BRK, eof);
      end
      S_DROP: frm_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ch         <= '0;
      cur_idx    <= '0;
      nxt_idx    <= '0;
      buf_len    <= '0;
      buf_addr   <= '0;
      beats      <= '0;
      eof        <= 1'b0;
      nxt_rdy    <= 1'b0;
      done_valid <= 1'b0;
      done_chan  <= '0;
      drop_valid <= 1'b0;
      drop_chan  <= '0;
    end else begin
      done_valid <= wb_fire && eof;
      drop_valid <= drop_end;
      if (wb_fire) done_chan <= ch;
      if (drop_end) drop_chan <= ch;
      unique case (state)
        S_IDLE: if (frm_valid) begin
          ch      <= frm_chan;
          cur_idx <= tbl_idx;
          state   <= S_RD1;
        end
        S_RD1: state <= S_RD1W;
        S_RD1W: begin
          if (rd_sync == SY_READY) begin
            nxt_idx <= rd_next;
            buf_len <= rd_len;
            state   <= S_RD0W;
          end else begin
            state <= S_DROP;
          end
        end
        S_RD0W: begin
          buf_addr <= mem_rdata[BAW-1:0];
          beats    <= '0;
          eof      <= 1'b0;
          state    <= S_FILL;
        end
        S_FILL: if (frm_valid) begin
          beats <= beats_n;
          if (frm_last) begin
            eof   <= 1'b1;
            state <= S_PEEK;
          end else if (buf_full) begin
            state <= S_PEEK;
          end
        end
        S_PEEK:  state <= S_PEEKW;
        S_PEEKW: begin
          nxt_rdy <= (rd_sync == SY_READY);
          state   <= S_WB;
        end
        S_WB: begin
          if (eof) state <= S_IDLE;
          else if (nxt_rdy) begin
            cur_idx <= nxt_idx;
            state   <= S_RD1;
          end else state <= S_DROP;
        end
        S_DROP: if (drop_end) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_word |-> ({beats, 3'b000} < buf_len));
  // R8
  drop_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DROP) |-> !mem_we);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!mem_req && !frm_ready));
  // R6
  wb_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (mem_wdata[33] == 1'b0));
  // R10
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && drop_valid));
  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(wb_fire));
endmodule

// File: tb/sim_rxw_walker.sv
module sim_rxw_walker;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] area_base = BASE;
  logic        hd_load = 1'b0;
  logic [1:0]  hd_chan = '0;
  logic [15:0] hd_index = '0;
  logic        frm_valid = 1'b0, frm_last = 1'b0;
  logic [1:0]  frm_chan = '0;
  logic [63:0] frm_data = '0;
  logic        frm_ready, mem_req, mem_we;
  logic [28:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic        done_valid, drop_valid;
  logic [1:0]  done_chan, drop_chan;

  rxw_walker #(.NCHAN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .area_base(area_base),
    .hd_load(hd_load), .hd_chan(hd_chan), .hd_index(hd_index),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_chan(frm_chan),
    .frm_data(frm_data), .frm_last(frm_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_chan(done_chan),
    .drop_valid(drop_valid), .drop_chan(drop_chan)
  );

  logic [63:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  int n_done = 0, n_drop = 0;
  logic [1:0] last_done_ch = '0, last_drop_ch = '0;
  always @(posedge clk) begin
    if (done_valid) begin n_done <= n_done + 1; last_done_ch <= done_chan; end
    if (drop_valid) begin n_drop <= n_drop + 1; last_drop_ch <= drop_chan; end
  end

  int checks = 0, errors = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // bench-side address arithmetic (R1)
  function automatic int ctl_w(input int idx); return (BASE / 8) + idx * 2 + 1; endfunction
  function automatic int ptr_w(input int idx); return (BASE / 8) + idx * 2; endfunction
  function automatic int buf_b(input int idx); return 32'h4000 + (idx % 40) * 256; endfunction
  function automatic logic [63:0] pat(input int s, input int k);
    return {16'hC0DE, 16'(s), 32'(k)};
  endfunction
  localparam logic [63:0] FILLER = 64'hDEAD_BEEF_0BAD_F00D;

  task automatic put_desc(input int idx, input int len, input int nxt, input logic [1:0] sy);
    mem[ctl_w(idx)] = {29'd0, 1'b0, sy, 16'(len), 16'(nxt)};
    mem[ptr_w(idx)] = {32'd0, 32'(buf_b(idx))};
    for (int j = 0; j < 32; j++) mem[(buf_b(idx) / 8) + j] = FILLER;
  endtask

  task automatic load_head(input int ch, input int idx);
    @(negedge clk);
    hd_load = 1'b1; hd_chan = 2'(ch); hd_index = 16'(idx);
    @(negedge clk);
    hd_load = 1'b0;
  endtask

  task automatic send_frame(input int ch, input int n, input int s);
    @(negedge clk);
    for (int j = 0; j < n; j++) begin
      frm_valid = 1'b1; frm_chan = 2'(ch);
      frm_data = pat(s, j); frm_last = (j == n - 1);
      #1;
      while (!frm_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    frm_valid = 1'b0; frm_last = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // one sweep point: F words into a chain of C ready buffers of B words
  task automatic run_case(input int f, input int b, input int c, input int ch, input int s);
    int need, u, d0, e0, cnt;
    logic drop;
    logic [63:0] w;
    for (int k = 0; k <= c; k++) put_desc(s + k, b * 8, s + k + 1, (k < c) ? 2'd3 : 2'd2);
    load_head(ch, s);
    d0 = n_done; e0 = n_drop;
    send_frame(ch, f, s);
    need = (f + b - 1) / b;
    u = (need < c) ? need : c;
    drop = f > c * b;
    for (int k = 0; k < u; k++) begin
      w = mem[ctl_w(s + k)];
      cnt = (k < u - 1 || drop) ? b * 8 : (f - k * b) * 8;
      chk("R5 count", 64'(w[31:16]), 64'(cnt));
      chk("R5 eof", 64'(w[34]), 64'((k == u - 1) && !drop));
      chk("R5 next", 64'(w[15:0]), 64'(s + k + 1));
      chk("R6 sync", 64'(w[33:32]), (k + 1 < c) ? 64'd0 : 64'd1);
      for (int j = 0; j < cnt / 8; j++)
        chk("R3 R4 data", mem[(buf_b(s + k) / 8) + j], pat(s, k * b + j));
      if (cnt / 8 < 32) chk("R3 bound", mem[(buf_b(s + k) / 8) + cnt / 8], FILLER);
    end
    for (int k = u; k <= c; k++)
      chk("R2 untouched", 64'(mem[ctl_w(s + k)][33:32]), (k < c) ? 64'd3 : 64'd2);
    chk("R10 done count", 64'(n_done - d0), drop ? 64'd0 : 64'd1);
    chk("R8 drop count", 64'(n_drop - e0), drop ? 64'd1 : 64'd0);
    if (drop) chk("R8 drop chan", 64'(last_drop_ch), 64'(ch));
    else chk("R10 done chan", 64'(last_done_ch), 64'(ch));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    // R12
    chk("R12 req", 64'(mem_req), 0);
    chk("R12 ready", 64'(frm_ready), 0);
    chk("R12 events", 64'({done_valid, drop_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep R1..R6, R8, R10
    begin
      int cs;
      cs = 0;
      for (int f = 1; f <= 6; f++)
        for (int b = 1; b <= 3; b++)
          for (int c = 0; c <= 3; c++) begin
            run_case(f, b, c, cs % 4, (cs % 8) * 5);
            cs++;
          end
    end

    // R7: frame ending mid-buffer, next frame in next descriptor
    for (int k = 0; k < 4; k++) put_desc(k, 24, k + 1, (k < 3) ? 2'd3 : 2'd2);
    load_head(0, 0);
    send_frame(0, 1, 50);
    send_frame(0, 2, 51);
    chk("R7 first count", 64'(mem[ctl_w(0)][31:16]), 8);
    chk("R7 second eof", 64'(mem[ctl_w(1)][34]), 1);
    chk("R7 second count", 64'(mem[ctl_w(1)][31:16]), 16);
    chk("R7 second start", mem[buf_b(1) / 8], pat(51, 0));
    chk("R7 rest unused", mem[buf_b(0) / 8 + 1], FILLER);

    // R9: repeated discards, then normal service
    put_desc(30, 8, 31, 2'd2);
    load_head(3, 30);
    e0 = n_drop;
    for (int r = 0; r < 9; r++) send_frame(3, 5, 60);
    chk("R9 drops", 64'(n_drop - e0), 9);
    chk("R9 no write", 64'(mem[ctl_w(30)][33:32]), 2);
    run_case(3, 2, 2, 3, 32);

    // R11: channels advance independently
    for (int k = 0; k < 3; k++) put_desc(k, 8, k + 1, (k < 2) ? 2'd3 : 2'd2);
    for (int k = 20; k < 23; k++) put_desc(k, 8, k + 1, (k < 22) ? 2'd3 : 2'd2);
    load_head(1, 0);
    load_head(2, 20);
    d0 = n_done;
    send_frame(2, 1, 70);
    chk("R11 ch2 used", 64'(mem[ctl_w(20)][34]), 1);
    chk("R11 ch1 idle", 64'(mem[ctl_w(0)][33:32]), 3);
    chk("R11 chan", 64'(last_done_ch), 2);
    send_frame(1, 1, 71);
    chk("R11 ch1 used", mem[buf_b(0) / 8], pat(71, 0));
    send_frame(2, 1, 72);
    chk("R11 ch2 advanced", mem[buf_b(21) / 8], pat(72, 0));
    chk("R11 done total", 64'(n_done - d0), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule